// File: doc/BRIEF.md
# Peripheral Register Self-Test Sequencer

This block masters a simple synchronous register bus after reset and checks that six memory-mapped peripheral chips hold their registers correctly. Each chip gets a write/read-back sweep over a fixed set of byte-wide registers. After that, a cross-chip pass looks for address-decode faults, where a register in one chip also answers to another chip's address.

A start pulse launches the sequence. It then loops with no further input. Each clean loop through both phases increments a pass counter and emits a one-cycle heartbeat. A mismatch stops the sweep and latches a sticky failure record: chip index, register offset, phase, expected byte and byte read. The record stays while a fixed restart delay runs. When the delay ends, the record and the pass counter clear and testing starts again from the first phase.

Top module: `periph_selftest`

## Requirements
- R1: After reset and before any start pulse, both strobes stay low, the pass counter is 0, and the heartbeat and fail flag are low.
- R2: Chips are visited in the index order 0 to 5, with base addresses 0x21000, 0x41000, 0x51000, 0x61000, 0x49000 and 0x59000. The bus address is the base plus the register offset.
- R3: In phase one, each chip's visit opens with a write of 0x00 to its offset 0x00 (interrupt master control).
- R4: In phase one, each chip's registers are tested in ascending offset order 0x02, 0x03, 0x04, 0x16, 0x17, 0x18, 0x19, 0x1A, 0x1B. Each test writes the pattern and then reads the same address.
- R5: Phase one repeats the six-chip sweep for patterns 0x00 through 0xFF. Phase two begins when the 8-bit pattern wraps to 0x00.
- R6: Phase two first writes 0x00 to offset 0x02 of all six chips in order. Then, for each pattern 0x00 to 0xFF and each chip in order, it reads offset 0x02 and writes pattern+1 (mod 256) to it.
- R7: A read that differs from the pattern sets failFlag. It latches the chip index (0..5), the offset, the phase (1 or 2, two-bit code), the pattern as expected value and the byte read. Bus activity stops.
- R8: failFlag stays high for exactly 255 cycles. The record and the pass counter then clear, and the sequence restarts at chip 0, offset 0x00, pattern 0x00.
- R9: On completing phase two, passCount increments by one in the same cycle that heartbeat is high for exactly one cycle. Phase one then restarts.
- R10: An access holds its strobe, address and write data until busReady is high. A read takes busRdata in the cycle busReady is seen. Read and write strobes are never high together.
- R11: A start pulse in any state clears the counters and the failure record, and restarts at phase one. No strobe is driven while start is high.
- R12: If one chip's offset 0x02 aliases a chip visited earlier, phase one passes and phase two reports the later chip, offset 0x02, expected 0x00, read 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the whole sequence |
| busAddr | output | 20 | Bus address |
| busWdata | output | 8 | Write data |
| busWr | output | 1 | Write strobe |
| busRd | output | 1 | Read strobe |
| busRdata | input | 8 | Read data |
| busReady | input | 1 | Access completes in this cycle |
| passCount | output | PASS_W (16) | Clean loops since last restart |
| heartbeat | output | 1 | One-cycle pulse per clean loop |
| failFlag | output | 1 | Sticky mismatch flag |
| failChip | output | 3 | Chip index of the mismatch |
| failOffset | output | 8 | Register offset of the mismatch |
| failPhase | output | 2 | 1 or 2 |
| failExpected | output | 8 | Pattern expected |
| failActual | output | 8 | Byte read |

## Verification
Any slip in the chip, register or pattern counters shows up at the bus address or write data in the very access where it occurs, because every completed access is compared with an independently generated sequence. A broken compare or capture path appears either as a spurious fail record within one read or as a missing record when faults are injected. Errors in the restart timer or the pass counter appear at the end of the 255-cycle window or at the first heartbeat, about 43k cycles in with random wait states.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 8;
  localparam int NUM_CHIPS = 6;
  localparam int NUM_REGS  = 9;
  localparam int CHIP_W    = $clog2(NUM_CHIPS);
  localparam int REG_W     = $clog2(NUM_REGS);

  typedef enum logic [1:0] {ADR_CTRL, ADR_TEST, ADR_VEC} addrSel_e;
  typedef enum logic [1:0] {WD_ZERO, WD_PAT, WD_BUMP} wdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     clrAll;
    logic     incReg;
    logic     clrReg;
    logic     incChip;
    logic     clrChip;
    logic     incPat;
    logic     capFail;
    logic     failInP2;
    logic     incPass;
    logic     runDelay;
  } pstCtl_t;

  function automatic logic [ADDR_W-1:0] chipBase(input logic [CHIP_W-1:0] idx);
    case (idx)
      3'd0:    return 20'h21000;
      3'd1:    return 20'h41000;
      3'd2:    return 20'h51000;
      3'd3:    return 20'h61000;
      3'd4:    return 20'h49000;
      default: return 20'h59000;
    endcase
  endfunction

  // vectors at 0x02..0x04, timer constants at 0x16..0x1B
  function automatic logic [7:0] testOffset(input logic [REG_W-1:0] idx);
    if (idx < 4'd3) return 8'h02 + 8'(idx);
    return 8'h13 + 8'(idx);
  endfunction
endpackage

// File: rtl/pst_datapath.sv
module pst_datapath import pst_pkg::*; #(
  parameter int PASS_W        = 16,
  parameter int RESTART_DELAY = 255
) (
  input  logic               clk,
  input  logic               rstN,
  input  pstCtl_t            ctl,
  input  logic [DATA_W-1:0]  busRdata,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  output logic               lastReg,
  output logic               lastChip,
  output logic               lastPat,
  output logic               mismatch,
  output logic               delayDone,
  output logic [PASS_W-1:0]  passCount,
  output logic               heartbeat,
  output logic               failFlag,
  output logic [CHIP_W-1:0]  failChip,
  output logic [7:0]         failOffset,
  output logic [1:0]         failPhase,
  output logic [DATA_W-1:0]  failExpected,
  output logic [DATA_W-1:0]  failActual
);
  localparam int DLY_W = $clog2(RESTART_DELAY + 1);

  logic [DATA_W-1:0] pattern;
  logic [CHIP_W-1:0] chipIdx;
  logic [REG_W-1:0]  regIdx;
  logic [DLY_W-1:0]  delayCnt;
  logic [7:0]        curOffset;

  always_comb begin
    unique case (ctl.addrSel)
      ADR_CTRL: curOffset = 8'h00;
      ADR_VEC:  curOffset = 8'h02;
      default:  curOffset = testOffset(regIdx);
    endcase
    unique case (ctl.wdSel)
      WD_ZERO: busWdata = '0;
      WD_BUMP: busWdata = pattern + 1'b1;
      default: busWdata = pattern;
    endcase
  end

  assign busAddr   = chipBase(chipIdx) + {{(ADDR_W-8){1'b0}}, curOffset};
  assign lastReg   = (regIdx == REG_W'(NUM_REGS - 1));
  assign lastChip  = (chipIdx == CHIP_W'(NUM_CHIPS - 1));
  assign lastPat   = (pattern == '1);
  assign mismatch  = (busRdata != pattern);
  assign delayDone = (delayCnt == DLY_W'(RESTART_DELAY - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pattern <= '0; chipIdx <= '0; regIdx <= '0; delayCnt <= '0;
      passCount <= '0; heartbeat <= 1'b0; failFlag <= 1'b0;
      failChip <= '0; failOffset <= '0; failPhase <= '0;
      failExpected <= '0; failActual <= '0;
    end else begin
      heartbeat <= ctl.incPass;
      if (ctl.clrAll) begin
        pattern <= '0; chipIdx <= '0; regIdx <= '0; delayCnt <= '0;
        passCount <= '0; failFlag <= 1'b0;
        failChip <= '0; failOffset <= '0; failPhase <= '0;
        failExpected <= '0; failActual <= '0;
      end else begin
        if (ctl.clrReg)       regIdx <= '0;
        else if (ctl.incReg)  regIdx <= regIdx + 1'b1;
        if (ctl.clrChip)      chipIdx <= '0;
        else if (ctl.incChip) chipIdx <= chipIdx + 1'b1;
        if (ctl.incPat)       pattern <= pattern + 1'b1;
        if (ctl.incPass)      passCount <= passCount + 1'b1;
        if (ctl.capFail) begin
          failFlag     <= 1'b1;
          failChip     <= chipIdx;
          failOffset   <= curOffset;
          failPhase    <= ctl.failInP2 ? 2'd2 : 2'd1;
          failExpected <= pattern;
          failActual   <= busRdata;
          delayCnt     <= '0;
        end else if (ctl.runDelay) begin
          delayCnt <= delayCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pst_control.sv
module pst_control import pst_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    busReady,
  input  logic    lastReg,
  input  logic    lastChip,
  input  logic    lastPat,
  input  logic    mismatch,
  input  logic    delayDone,
  output logic    busWr,
  output logic    busRd,
  output pstCtl_t ctl
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_WR, ST_RD, ST_CLR2, ST_RD2, ST_WR2, ST_HOLD
  } state_e;

  state_e state, nextState;
  logic   wrReq, rdReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.addrSel = ADR_TEST;
    ctl.wdSel   = WD_PAT;
    wrReq       = 1'b0;
    rdReq       = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_CTRL: begin
        wrReq = 1'b1; ctl.addrSel = ADR_CTRL; ctl.wdSel = WD_ZERO;
        if (busReady) nextState = ST_WR;
      end
      ST_WR: begin
        wrReq = 1'b1;
        if (busReady) nextState = ST_RD;
      end
      ST_RD: begin
        rdReq = 1'b1;
        if (busReady) begin
          if (mismatch) begin
            ctl.capFail = 1'b1; nextState = ST_HOLD;
          end else if (!lastReg) begin
            ctl.incReg = 1'b1; nextState = ST_WR;
          end else begin
            ctl.clrReg = 1'b1; nextState = ST_CTRL;
            if (!lastChip) ctl.incChip = 1'b1;
            else begin
              ctl.clrChip = 1'b1; ctl.incPat = 1'b1;
              if (lastPat) nextState = ST_CLR2;
            end
          end
        end
      end
      ST_CLR2: begin
        wrReq = 1'b1; ctl.addrSel = ADR_VEC; ctl.wdSel = WD_ZERO;
        if (busReady) begin
          if (lastChip) begin ctl.clrChip = 1'b1; nextState = ST_RD2; end
          else ctl.incChip = 1'b1;
        end
      end
      ST_RD2: begin
        rdReq = 1'b1; ctl.addrSel = ADR_VEC;
        if (busReady) begin
          if (mismatch) begin
            ctl.capFail = 1'b1; ctl.failInP2 = 1'b1; nextState = ST_HOLD;
          end else nextState = ST_WR2;
        end
      end
      ST_WR2: begin
        wrReq = 1'b1; ctl.addrSel = ADR_VEC; ctl.wdSel = WD_BUMP;
        if (busReady) begin
          nextState = ST_RD2;
          if (!lastChip) ctl.incChip = 1'b1;
          else begin
            ctl.clrChip = 1'b1; ctl.incPat = 1'b1;
            if (lastPat) begin ctl.incPass = 1'b1; nextState = ST_CTRL; end
          end
        end
      end
      ST_HOLD: begin
        ctl.runDelay = 1'b1;
        if (delayDone) begin ctl.clrAll = 1'b1; nextState = ST_CTRL; end
      end
      default: nextState = ST_IDLE;
    endcase
    if (start) begin
      ctl        = '0;
      ctl.clrAll = 1'b1;
      nextState  = ST_CTRL;
    end
  end

  assign busWr = wrReq && !start;
  assign busRd = rdReq && !start;
endmodule

// File: rtl/periph_selftest.sv
module periph_selftest import pst_pkg::*; #(
  parameter int PASS_W        = 16,
  parameter int RESTART_DELAY = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWr,
  output logic              busRd,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic [PASS_W-1:0] passCount,
  output logic              heartbeat,
  output logic              failFlag,
  output logic [CHIP_W-1:0] failChip,
  output logic [7:0]        failOffset,
  output logic [1:0]        failPhase,
  output logic [DATA_W-1:0] failExpected,
  output logic [DATA_W-1:0] failActual
);
  pstCtl_t ctl;
  logic lastReg, lastChip, lastPat, mismatch, delayDone;

  pst_control ctrl_i (
    .clk, .rstN, .start, .busReady,
    .lastReg, .lastChip, .lastPat, .mismatch, .delayDone,
    .busWr, .busRd, .ctl
  );

  pst_datapath #(.PASS_W(PASS_W), .RESTART_DELAY(RESTART_DELAY)) dp_i (
    .clk, .rstN, .ctl, .busRdata, .busAddr, .busWdata,
    .lastReg, .lastChip, .lastPat, .mismatch, .delayDone,
    .passCount, .heartbeat, .failFlag, .failChip, .failOffset,
    .failPhase, .failExpected, .failActual
  );
endmodule

// File: rtl/periph_selftest_chk.sv
module periph_selftest_chk import pst_pkg::*; #(
  parameter int PASS_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busWr,
  input logic              busRd,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [PASS_W-1:0] passCount,
  input logic              heartbeat,
  input logic              failFlag,
  input logic [1:0]        failPhase,
  input logic [DATA_W-1:0] failExpected,
  input logic [DATA_W-1:0] failActual
);
  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busReady |=> start || (busWr && $stable(busAddr) && $stable(busWdata)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busReady |=> start || (busRd && $stable(busAddr)));

  // R9
  beat_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    heartbeat |-> passCount == $past(passCount) + 1'b1);

  // R9
  beat_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    heartbeat |=> !heartbeat);

  // R7
  fail_differs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> failActual != failExpected);

  // R7
  fail_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> (failPhase == 2'd1 || failPhase == 2'd2));

  // R8
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> !busWr && !busRd);
endmodule

bind periph_selftest periph_selftest_chk #(.PASS_W(PASS_W)) chk_i (.*);

// File: tb/periph_selftest_tb_top.sv
`timescale 1ns/1ps
module periph_selftest_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] busAddr;
  logic [7:0]  busWdata, busRdata;
  logic        busWr, busRd, busReady;
  logic [15:0] passCount;
  logic        heartbeat, failFlag;
  logic [2:0]  failChip;
  logic [7:0]  failOffset;
  logic [1:0]  failPhase;
  logic [7:0]  failExpected, failActual;

  int nChecks = 0, nFails = 0;
  logic [7:0] regs [6][32];
  int faultMode = 0;            // 0 none, 1 stuck bit, 2 alias
  int fChip = 0, fOff = 2, fBit = 0, aliasFrom = 1, aliasTo = 0;

  bit         expWr[$];
  logic [19:0] expAddr[$];
  logic [7:0]  expData[$];
  string       expTag[$];

  always #2.5 clk = ~clk;

  periph_selftest dut_i (
    .clk, .rstN, .start, .busAddr, .busWdata, .busWr, .busRd,
    .busRdata, .busReady, .passCount, .heartbeat, .failFlag,
    .failChip, .failOffset, .failPhase, .failExpected, .failActual
  );

  function automatic logic [19:0] refBase(input int c);
    case (c)
      0: return 20'h21000;  1: return 20'h41000;  2: return 20'h51000;
      3: return 20'h61000;  4: return 20'h49000;  default: return 20'h59000;
    endcase
  endfunction

  function automatic int refOff(input int r);
    return (r < 3) ? 2 + r : 'h13 + r;
  endfunction

  function automatic int decode(input logic [19:0] a);
    for (int i = 0; i < 6; i++)
      if ((a & ~20'h1F) == refBase(i)) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(input bit w, input logic [19:0] a,
                               input logic [7:0] d, input string t);
    expWr.push_back(w); expAddr.push_back(a); expData.push_back(d); expTag.push_back(t);
  endfunction

  function automatic void clearQ();
    expWr.delete(); expAddr.delete(); expData.delete(); expTag.delete();
  endfunction

  // expected access list of one clean loop, built from the requirements
  function automatic void buildPass();
    for (int p = 0; p < 256; p++)
      for (int c = 0; c < 6; c++) begin
        push(1'b1, refBase(c), 8'h00, "R2,R3");
        for (int r = 0; r < 9; r++) begin
          push(1'b1, refBase(c) + 20'(refOff(r)), 8'(p), "R4,R5");
          push(1'b0, refBase(c) + 20'(refOff(r)), 8'h00, "R4");
        end
      end
    for (int c = 0; c < 6; c++) push(1'b1, refBase(c) + 20'h2, 8'h00, "R6");
    for (int p = 0; p < 256; p++)
      for (int c = 0; c < 6; c++) begin
        push(1'b0, refBase(c) + 20'h2, 8'h00, "R6");
        push(1'b1, refBase(c) + 20'h2, 8'(p + 1), "R6");
      end
  endfunction

  // register-file stubs with injectable faults
  always_comb begin
    int c;
    int o;
    c = decode(busAddr);
    o = int'(busAddr[4:0]);
    busRdata = 8'h00;
    if (c >= 0) begin
      if (faultMode == 2 && c == aliasFrom && o == 2) c = aliasTo;
      busRdata = regs[c][o];
      if (faultMode == 1 && c == fChip && o == fOff) busRdata = busRdata | (8'h1 << fBit);
    end
  end

  // ready generator, stub writes and access monitor
  initial begin
    bit heldPend;
    bit heldWr;
    logic [19:0] heldAddr;
    heldPend = 1'b0; heldWr = 1'b0; heldAddr = '0;
    busReady = 1'b0;
    forever begin
      @(negedge clk);
      busReady = ($urandom_range(99) < 75);
      if (rstN) begin
        if (heartbeat)
          check(expAddr.size() == 0, "R9", "all accesses of the loop done at heartbeat",
                longint'(expAddr.size()), 0);
        if (failFlag) clearQ();
        if (heldPend && !start)
          check((busWr || busRd) && busWr == heldWr && busAddr == heldAddr, "R10",
                "access held while not ready", longint'(busAddr), longint'(heldAddr));
        heldPend = 1'b0;
        if (busWr || busRd) begin
          if (!busReady) begin
            heldPend = 1'b1; heldWr = busWr; heldAddr = busAddr;
          end else begin
            bit ew;
            logic [19:0] ea;
            logic [7:0] ed;
            string et;
            if (expAddr.size() == 0) buildPass();
            ew = expWr.pop_front(); ea = expAddr.pop_front();
            ed = expData.pop_front(); et = expTag.pop_front();
            check(busWr == ew && busAddr == ea && (!ew || busWdata == ed), et, "access",
                  longint'({busWr, busAddr, busWdata}),
                  longint'({ew, ea, ew ? ed : busWdata}));
            if (busWr) begin
              int c;
              int o;
              c = decode(busAddr);
              o = int'(busAddr[4:0]);
              if (faultMode == 2 && c == aliasFrom && o == 2) c = aliasTo;
              if (c >= 0) regs[c][o] = busWdata;
            end
          end
        end
      end
    end
  end

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1; clearQ();
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int cnt;
    void'($urandom(32'd4711));
    for (int c = 0; c < 6; c++)
      for (int o = 0; o < 32; o++) regs[c][o] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: idle after reset
    repeat (12) begin
      @(negedge clk);
      check(!busWr && !busRd && passCount == 0 && !failFlag && !heartbeat, "R1",
            "idle outputs", longint'({busWr, busRd, failFlag, heartbeat, passCount}), 0);
    end

    // first clean loop, compared access by access
    pulseStart();
    do @(negedge clk); while (!heartbeat);
    check(passCount == 16'd1, "R9", "passCount after loop", longint'(passCount), 1);
    @(negedge clk);
    check(!heartbeat, "R9", "heartbeat one cycle", longint'(heartbeat), 0);

    // R11: start mid-run clears the counter; a stuck bit is armed for the new run
    repeat (3000) @(negedge clk);
    fChip = $urandom_range(5);
    fOff  = refOff($urandom_range(8));
    fBit  = $urandom_range(7);
    faultMode = 1;
    pulseStart();
    @(negedge clk);
    check(passCount == 0 && !failFlag, "R11", "start clears state",
          longint'({failFlag, passCount}), 0);

    // R7: stuck bit caught in phase one at pattern 0x00
    do @(negedge clk); while (!failFlag);
    faultMode = 0;
    check(failChip == 3'(fChip), "R7", "failChip", longint'(failChip), fChip);
    check(failOffset == 8'(fOff), "R7", "failOffset", longint'(failOffset), fOff);
    check(failPhase == 2'd1, "R7", "failPhase", longint'(failPhase), 1);
    check(failExpected == 8'h00, "R7", "failExpected", longint'(failExpected), 0);
    check(failActual == (8'h1 << fBit), "R7", "failActual",
          longint'(failActual), longint'(8'h1 << fBit));

    // R8: hold window length, then clean restart
    cnt = 1;
    forever begin
      @(negedge clk);
      if (!failFlag) break;
      cnt++;
    end
    check(cnt == 255, "R8", "fail hold cycles", cnt, 255);
    check(passCount == 0 && failChip == 0 && failActual == 0, "R8", "cleared after hold",
          longint'({passCount, failChip, failActual}), 0);
    while (!(busWr && busReady)) @(negedge clk);
    check(busAddr == 20'h21000 && busWdata == 8'h00, "R8", "restart access",
          longint'({busAddr, busWdata}), longint'({20'h21000, 8'h00}));

    // R12: offset 0x02 of a later chip aliases an earlier one
    aliasTo   = $urandom_range(4);
    aliasFrom = $urandom_range(5, aliasTo + 1);
    faultMode = 2;
    pulseStart();
    do @(negedge clk); while (!failFlag);
    check(failPhase == 2'd2, "R12", "phase one passes, phase two reports",
          longint'(failPhase), 2);
    check(failChip == 3'(aliasFrom), "R12", "aliased chip", longint'(failChip), aliasFrom);
    check(failOffset == 8'h02, "R12", "aliased offset", longint'(failOffset), 2);
    check(failExpected == 8'h00 && failActual == 8'h01, "R12", "aliased values",
          longint'({failExpected, failActual}), longint'({8'h00, 8'h01}));

    // R11: start during the hold window clears the record at once
    repeat (20) @(negedge clk);
    faultMode = 0;
    pulseStart();
    @(negedge clk);
    check(!failFlag && failPhase == 0, "R11", "start during hold",
          longint'({failFlag, failPhase}), 0);
    repeat (300) @(negedge clk);
    check(!failFlag, "R11", "clean run after restart", longint'(failFlag), 0);
    finishRun();
  end
endmodule